// File: doc/BRIEF.md
# Paged Monochrome Display Controller

This block drives a 128 by 64 single-colour display from a register write port. The frame is held in a 1024-byte buffer split into 8 pages of 128 columns, where every byte holds a vertical strip of 8 pixels. Writing a special 32-bit word to a steering register decides what later writes to the data register mean. They can be pixel bytes, page-select commands, or nothing at all.

In pixel mode each byte lands at the current page and column. The column then steps forward and wraps from 127 back to 0 inside the same page. A page-select command can arrive either through a dedicated instruction register or as a command-mode write to the data register. It chooses the page and returns the column to 0.

A separate scan port reads the frame back for display refresh. The refresh logic presents an x and y coordinate. One clock later the block returns the pixel bit and an intensity value scaled by a 3-bit brightness level.

Top module: `lcdp_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the steering state is "ignore", the page is 0, the column is 0, and both `pix_on` and `pix_int` are 0.
- R2: A write of 0x00100011 to offset 0x1AC selects pixel mode. A write of 0x00104011 to that offset selects command mode. Any other value written there selects the ignore mode.
- R3: In pixel mode, a write to offset 0x1C0 stores `wr_data[7:0]` at byte index page*128 + column. The column then becomes (column + 1) mod 128, and the page stays unchanged.
- R4: In ignore mode, a write to offset 0x1C0 changes neither the frame buffer nor the page nor the column.
- R5: In command mode, a write to offset 0x1C0 with a full 32-bit value between 0xB0 and 0xB7 sets the page to value - 0xB0 and the column to 0. Other values written there have no effect.
- R6: A write to offset 0x1BC with a value between 0xB0 and 0xB7 sets the page to value - 0xB0 and the column to 0, in any mode.
- R7: `pix_on` equals bit (y mod 8) of byte x + (y/8)*128, where x and y are the `scan_x` and `scan_y` values sampled one clock earlier. A write in that same cycle is not yet visible.
- R8: `pix_int` equals floor(255*L/7) when `pix_on` is 1 and 0 when `pix_on` is 0. L is `bright_lvl` sampled at the same edge as the scan coordinates.
- R9: Writes to any other offset, including 0x180 and 0x184, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte offset |
| wr_data | input | 32 | Register write value |
| scan_x | input | 7 | Scan column 0..127 |
| scan_y | input | 6 | Scan row 0..63 |
| bright_lvl | input | 3 | Brightness level 0..7 |
| pix_on | output | 1 | Pixel bit for the coordinate one clock earlier |
| pix_int | output | 8 | Scaled intensity, 0 for a dark pixel |

## Verification
A wrong steering mode, page or column has no port of its own. It shows up only when the next data-register write puts a byte in the wrong place, and that byte is seen one clock after the refresh logic scans its location. For this reason the bench follows every mode change and page jump with fresh writes and a scan of the affected strip. A fault in the buffer address mapping or the brightness scaling shows on `pix_on` or `pix_int` in the very next cycle. The bench compares a behavioural model against the outputs on every clock, over every byte the bench knows.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;
  localparam int REG_W = 32;
  localparam int OFS_W = 12;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_DATA = 2'd1,
    MODE_CMD  = 2'd2
  } lcd_mode_e;

  localparam logic [REG_W-1:0] WORD_DATA   = 32'h0010_0011;
  localparam logic [REG_W-1:0] WORD_CMD    = 32'h0010_4011;
  localparam logic [REG_W-1:0] PAGE_CMD_LO = 32'h0000_00B0;

  localparam logic [OFS_W-1:0] OFS_MODE  = 12'h1AC;
  localparam logic [OFS_W-1:0] OFS_INSTR = 12'h1BC;
  localparam logic [OFS_W-1:0] OFS_DATA  = 12'h1C0;
endpackage

// File: rtl/lcdp_wr_ctrl.sv
module lcdp_wr_ctrl
  import lcdp_pkg::*;
#(
  parameter int COLS   = 128,
  parameter int PAGES  = 8,
  parameter int BYTE_W = 8,
  localparam int COL_W = $clog2(COLS),
  localparam int PG_W  = $clog2(PAGES),
  localparam int FB_AW = COL_W + PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic              fb_we,
  output logic [FB_AW-1:0]  fb_waddr,
  output logic [BYTE_W-1:0] fb_wdata
);
  localparam logic [REG_W-1:0] PAGE_CMD_HI = PAGE_CMD_LO + REG_W'(PAGES - 1);
  localparam logic [COL_W-1:0] COL_LAST    = COL_W'(COLS - 1);

  lcd_mode_e        mode_q, mode_d;
  logic [PG_W-1:0]  page_q, page_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             hit_mode, hit_instr, hit_data, is_pg, pg_sel, store;
  logic             mode_en, pos_en;
  logic [REG_W-1:0] pg_off;

  always_comb begin
    hit_mode  = wr_en && (wr_addr == OFS_MODE);
    hit_instr = wr_en && (wr_addr == OFS_INSTR);
    hit_data  = wr_en && (wr_addr == OFS_DATA);
    is_pg     = (wr_data >= PAGE_CMD_LO) && (wr_data <= PAGE_CMD_HI);
    pg_off    = wr_data - PAGE_CMD_LO;
    pg_sel    = is_pg && (hit_instr || (hit_data && mode_q == MODE_CMD));
    store     = hit_data && (mode_q == MODE_DATA);

    mode_en = hit_mode;
    if (wr_data == WORD_DATA)     mode_d = MODE_DATA;
    else if (wr_data == WORD_CMD) mode_d = MODE_CMD;
    else                          mode_d = MODE_OFF;

    pos_en = pg_sel || store;
    page_d = pg_sel ? pg_off[PG_W-1:0] : page_q;
    if (pg_sel)                 col_d = '0;
    else if (col_q == COL_LAST) col_d = '0;
    else                        col_d = col_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      col_q  <= '0;
    end else if (pos_en) begin
      page_q <= page_d;
      col_q  <= col_d;
    end
  end

  assign fb_we    = store;
  assign fb_waddr = {page_q, col_q};
  assign fb_wdata = wr_data[BYTE_W-1:0];

  // R3: column steps by one after a stored byte
  p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (store && col_q != COL_LAST) |=> (col_q == $past(col_q) + 1'b1));
  // R3: column wraps inside the page
  p_col_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (store && col_q == COL_LAST) |=> (col_q == '0 && $stable(page_q)));
  // R4: ignore mode leaves position untouched
  p_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && mode_q == MODE_OFF) |=> ($stable(page_q) && $stable(col_q)));
  // R5: command-mode page select through the data register
  p_cmd_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && mode_q == MODE_CMD && is_pg) |=>
    (page_q == PG_W'($past(wr_data) - PAGE_CMD_LO) && col_q == '0));
  // R6: page select through the instruction register
  p_instr_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_instr && is_pg) |=>
    (page_q == PG_W'($past(wr_data) - PAGE_CMD_LO) && col_q == '0));
endmodule

// File: rtl/lcdp_fbuf.sv
module lcdp_fbuf #(
  parameter int COLS   = 128,
  parameter int PAGES  = 8,
  parameter int BYTE_W = 8,
  localparam int DEPTH = COLS * PAGES,
  localparam int FB_AW = $clog2(DEPTH),
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [FB_AW-1:0]  waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [FB_AW-1:0]  raddr,
  input  logic [BIT_W-1:0]  rbit,
  output logic              pix_q
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic              pix_d;

  always_comb pix_d = mem[raddr][rbit];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= 1'b0;
    end else begin
      pix_q <= pix_d;
    end
  end
endmodule

// File: rtl/lcdp_shade.sv
module lcdp_shade #(
  parameter int INT_W = 8,
  parameter int LVL_W = 3,
  localparam int PROD_W = INT_W + LVL_W,
  localparam int FULL = (1 << INT_W) - 1,
  localparam int LVL_MAX = (1 << LVL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl,
  input  logic             pix_on,
  output logic [INT_W-1:0] pix_int
);
  logic [LVL_W-1:0]  lvl_q;
  logic [PROD_W-1:0] prod, quo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      lvl_q <= lvl;
    end
  end

  always_comb begin
    prod    = PROD_W'(FULL) * PROD_W'(lvl_q);
    quo     = prod / PROD_W'(LVL_MAX);
    pix_int = pix_on ? quo[INT_W-1:0] : '0;
  end
endmodule

// File: rtl/lcdp_ctrl.sv
module lcdp_ctrl
  import lcdp_pkg::*;
#(
  parameter int COLS   = 128,
  parameter int PAGES  = 8,
  parameter int BYTE_W = 8,
  parameter int INT_W  = 8,
  parameter int LVL_W  = 3,
  localparam int X_W   = $clog2(COLS),
  localparam int PG_W  = $clog2(PAGES),
  localparam int BIT_W = $clog2(BYTE_W),
  localparam int Y_W   = PG_W + BIT_W,
  localparam int FB_AW = X_W + PG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [11:0]      wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [X_W-1:0]   scan_x,
  input  logic [Y_W-1:0]   scan_y,
  input  logic [LVL_W-1:0] bright_lvl,
  output logic             pix_on,
  output logic [INT_W-1:0] pix_int
);
  logic              fb_we;
  logic [FB_AW-1:0]  fb_waddr, fb_raddr;
  logic [BYTE_W-1:0] fb_wdata;

  assign fb_raddr = {scan_y[Y_W-1:BIT_W], scan_x};

  lcdp_wr_ctrl #(.COLS(COLS), .PAGES(PAGES), .BYTE_W(BYTE_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fb_we(fb_we), .fb_waddr(fb_waddr), .fb_wdata(fb_wdata)
  );

  lcdp_fbuf #(.COLS(COLS), .PAGES(PAGES), .BYTE_W(BYTE_W)) u_fb (
    .clk(clk), .rst_n(rst_n), .we(fb_we), .waddr(fb_waddr), .wdata(fb_wdata),
    .raddr(fb_raddr), .rbit(scan_y[BIT_W-1:0]), .pix_q(pix_on)
  );

  lcdp_shade #(.INT_W(INT_W), .LVL_W(LVL_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .lvl(bright_lvl), .pix_on(pix_on), .pix_int(pix_int)
  );

  // R8: a lit pixel at top brightness shows full intensity
  p_full_at_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_on && $past(bright_lvl) == {LVL_W{1'b1}}) |-> (pix_int == {INT_W{1'b1}}));
  // R1: outputs are dark while in reset
  p_reset_dark_r1: assert property (@(posedge clk)
    !rst_n |-> (!pix_on && pix_int == '0));
endmodule

// File: tb/lcdp_ctrl_tb.sv
`timescale 1ns/100ps
module lcdp_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  scan_x = '0;
  logic [5:0]  scan_y = '0;
  logic [2:0]  bright_lvl = '0;
  logic        pix_on;
  logic [7:0]  pix_int;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  bit [7:0] m_mem [1024];
  bit       m_known [1024];
  int m_mode = 0, m_page = 0, m_col = 0;
  bit exp_ok = 0, exp_on = 0;
  int exp_int = 0;

  always #2.5 clk = ~clk;

  lcdp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .scan_x(scan_x), .scan_y(scan_y), .bright_lvl(bright_lvl),
    .pix_on(pix_on), .pix_int(pix_int)
  );

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_page = 0; m_col = 0;
      exp_ok = 1; exp_on = 0; exp_int = 0;
    end else begin
      int a;
      a = int'(scan_x) + (int'(scan_y) / 8) * 128;
      exp_ok = m_known[a];
      exp_on = m_mem[a][int'(scan_y) % 8];
      exp_int = exp_on ? (255 * int'(bright_lvl)) / 7 : 0;
      if (wr_en) begin
        bit pg;
        pg = (wr_data >= 32'hB0) && (wr_data <= 32'hB7);
        if (wr_addr == 12'h1AC)
          m_mode = (wr_data == 32'h0010_0011) ? 1 : (wr_data == 32'h0010_4011) ? 2 : 0;
        else if (wr_addr == 12'h1BC) begin
          if (pg) begin m_page = int'(wr_data) - 176; m_col = 0; end
        end else if (wr_addr == 12'h1C0) begin
          if (m_mode == 1) begin
            m_mem[m_page * 128 + m_col] = wr_data[7:0];
            m_known[m_page * 128 + m_col] = 1;
            m_col = (m_col + 1) % 128;
          end else if (m_mode == 2 && pg) begin
            m_page = int'(wr_data) - 176; m_col = 0;
          end
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (exp_ok) begin
      checks++;
      if (pix_on !== exp_on || int'(pix_int) != exp_int) begin
        errors++;
        $display("FAIL %s: pix_on=%0b pix_int=%0d expected pix_on=%0b pix_int=%0d",
                 cur_req, pix_on, pix_int, exp_on, exp_int);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #0.5;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #0.5;
    wr_en = 1'b0;
  endtask

  task automatic scan(input int x0, input int x1, input int y0, input int y1);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        @(negedge clk); #0.5;
        scan_x = 7'(x); scan_y = 6'(y);
      end
    @(negedge clk); #0.5;
  endtask

  initial begin
    // R1: reset values on the outputs
    cur_req = "R1";
    repeat (3) @(negedge clk);
    #0.5 rst_n = 1'b1;
    bright_lvl = 3'd7;
    // R1/R2: page 0 column 0 after reset, pixel mode entry
    reg_wr(12'h1AC, 32'h0010_0011);
    reg_wr(12'h1C0, 32'hFFFF_FFA5);
    cur_req = "R1";
    scan(0, 0, 0, 7);
    // R3: fill a page past its end to force the column wrap
    cur_req = "R3";
    for (int i = 0; i < 130; i++) reg_wr(12'h1C0, 32'(i * 37 + 3));
    scan(0, 127, 0, 7);
    // R5: command mode selects page 3, non-command value ignored
    cur_req = "R5";
    reg_wr(12'h1AC, 32'h0010_4011);
    reg_wr(12'h1C0, 32'h0000_01B3);
    reg_wr(12'h1C0, 32'h0000_00B3);
    reg_wr(12'h1C0, 32'h0000_0055);
    reg_wr(12'h1AC, 32'h0010_0011);
    reg_wr(12'h1C0, 32'h0000_00C3);
    reg_wr(12'h1C0, 32'h0000_003C);
    scan(0, 3, 24, 31);
    // R4: ignore mode drops data writes; next byte lands at column 2
    cur_req = "R4";
    reg_wr(12'h1AC, 32'h1234_5678);
    reg_wr(12'h1C0, 32'h0000_00FF);
    reg_wr(12'h1C0, 32'h0000_00B6);
    reg_wr(12'h1AC, 32'h0010_0011);
    reg_wr(12'h1C0, 32'h0000_0081);
    scan(0, 4, 24, 31);
    // R6: instruction register page select while in pixel mode
    cur_req = "R6";
    reg_wr(12'h1BC, 32'h0000_00B7);
    reg_wr(12'h1C0, 32'h0000_00E7);
    reg_wr(12'h1BC, 32'h0000_00B8);
    reg_wr(12'h1C0, 32'h0000_0018);
    scan(0, 2, 56, 63);
    // R9: writes to other offsets change nothing
    cur_req = "R9";
    reg_wr(12'h180, 32'h0000_00B2);
    reg_wr(12'h184, 32'h0000_4011);
    reg_wr(12'h1C4, 32'h0000_00B1);
    reg_wr(12'h1C0, 32'h0000_0066);
    scan(0, 3, 56, 63);
    // R7: scattered coordinates, one-cycle latency, write seen next cycle
    cur_req = "R7";
    scan(120, 127, 0, 7);
    scan(0, 127, 28, 28);
    // R8: every brightness level on lit and dark pixels
    cur_req = "R8";
    for (int l = 0; l < 8; l++) begin
      bright_lvl = 3'(l);
      scan(0, 3, 0, 7);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule